// File: doc/BRIEF.md
# CardBus Function Event and Wake Status Registers

This block holds the event, event-mask and present-state registers of a CardBus network function. It turns their contents into two outputs: a registered status-change request (`status_change_o`, the card's wake signal to the host) and a registered active-high interrupt request (`irq_o`, to be inverted into the active-low interrupt pin by the pad logic). A small synchronous register bus reaches the three registers. The bus carries a space qualifier, an address, read and write strobes, 32-bit write data with per-byte enables, read data and a ready flag. Only memory-space accesses are decoded. An access with the space qualifier low is ignored completely.

The block has two reset domains. `por_i` is the power-up reset and clears everything. `rst_i` is the combined hardware/software reset. It clears only the interrupt status bit, the interrupt enable and the interrupt output, so wake state and wake enables survive it. The wake status bit also clears itself when the power-management status input falls. The status-change output is gated by the power-management enable input as well as by two mask bits.

Top module: `fn_event_regs`

## Requirements
- R1: Word offsets relative to `BASE_OFF` (default 0x80). +0x0 is the event register, +0x4 is the mask register and +0x8 is the present-state register. Event bit 4 is wake status and bit 15 is interrupt status. Mask bit 4 is wake enable, bit 14 is wake summary enable and bit 15 is interrupt enable. Every other bit reads 0, and any other address (including +0xC) reads 0.
- R2: An access with `mem_space_i` low changes no register, gives no `ready_o`, and returns read data 0.
- R3: Event bit 4 is set by a `wake_evt_i` pulse. It is cleared by writing 1 to bit 4 with byte enable 0 set, and by `por_i`. `rst_i` leaves it unchanged.
- R4: Event bit 4 clears on the clock edge at which `pme_status_i` is first seen low after being high.
- R5: Event bit 15 is set on every edge where `irq_pend_i` is high and stays set after that input drops. It is cleared by writing 1 to bit 15 with byte enable 1 set, by `rst_i`, or by `por_i`.
- R6: Mask bits 4, 14 and 15 are read/write through byte enables 0 and 1. Bits 4 and 14 are cleared only by `por_i`. Bit 15 is also cleared by `rst_i`.
- R7: `status_change_o` is high one cycle after event bit 4, mask bit 4, mask bit 14 and `pme_enable_i` are all high. It is low whenever `pme_enable_i` was low on the previous edge.
- R8: `irq_o` is high one cycle after both event bit 15 and mask bit 15 are high. It is low on the cycle after `rst_i`.
- R9: If a wake or interrupt set event and a write-1-clear of the same bit fall on one edge, the bit ends up set.
- R10: The present-state register returns the live level of `wake_evt_i` in bit 4 and of `irq_pend_i` in bit 15. Writes to it change nothing.
- R11: A memory-space access gives `ready_o` high and registered `rdata_o` on the next cycle. Otherwise `ready_o` is low and `rdata_o` is 0. Writes to reserved bits and to lanes whose byte enable is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-up reset, synchronous, active high |
| rst_i | input | 1 | Hardware/software reset, synchronous, active high |
| mem_space_i | input | 1 | 1 = memory-space access, 0 = I/O-space access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte enables for write data |
| rdata_o | output | DATA_W | Registered read data |
| ready_o | output | 1 | Access completed (one cycle later) |
| wake_evt_i | input | 1 | Power-management event pulse |
| irq_pend_i | input | 1 | Interrupt pending level |
| pme_status_i | input | 1 | PME status bit from configuration space |
| pme_enable_i | input | 1 | PME enable bit from configuration space |
| status_change_o | output | 1 | Card status-change (wake) request |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench targets the places where the two reset domains meet. A wake bit that `rst_i` wiped, or an interrupt enable that only `por_i` cleared, would show up as wrong read-back after a mid-run `rst_i`. Write-1-clear is tried on the wrong byte lane and together with a set event. A design that ignored byte enables, or let the clear win, would lose the pending bit. The falling edge of `pme_status_i` is exercised on its own, and a design that cleared on the level instead of the edge would drop the wake bit too early. I/O-space accesses, writes to the present-state word and unmapped reads confirm that nothing is written and that the read data stays 0.

// File: rtl/fev_pkg.sv
package fev_pkg;

  // bit positions decoded by host software
  localparam int WAKE_BIT = 4;
  localparam int SUMM_BIT = 14;
  localparam int IRQ_BIT  = 15;

  typedef struct packed {
    logic wake;
    logic irq;
  } evt_t;

  typedef struct packed {
    logic wake_en;
    logic summ_en;
    logic irq_en;
  } mask_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EVT,
    SEL_MASK,
    SEL_PRES
  } sel_e;

endpackage

// File: rtl/fev_decode.sv
module fev_decode
  import fev_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE_OFF = 8'h80
) (
  input  logic              mem_space_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic              acc_o,
  output logic              wr_evt_o,
  output logic              wr_mask_o
);

  localparam logic [ADDR_W-1:0] EVT_OFF  = BASE_OFF;
  localparam logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(BASE_OFF + 4);
  localparam logic [ADDR_W-1:0] PRES_OFF = ADDR_W'(BASE_OFF + 8);

  always_comb begin
    sel_o = SEL_NONE;
    if (mem_space_i) begin
      if (addr_i == EVT_OFF)       sel_o = SEL_EVT;
      else if (addr_i == MASK_OFF) sel_o = SEL_MASK;
      else if (addr_i == PRES_OFF) sel_o = SEL_PRES;
    end
  end

  assign acc_o     = mem_space_i & (rd_i | wr_i);
  assign wr_evt_o  = wr_i & (sel_o == SEL_EVT);
  assign wr_mask_o = wr_i & (sel_o == SEL_MASK);

endmodule

// File: rtl/fev_event_bits.sv
module fev_event_bits
  import fev_pkg::*;
(
  input  logic clk,
  input  logic por_i,
  input  logic rst_i,
  input  logic wake_evt_i,
  input  logic irq_pend_i,
  input  logic pme_status_i,
  input  logic clr_wake_i,
  input  logic clr_irq_i,
  output evt_t evt_o
);

  logic pme_q;
  logic pme_fall;

  assign pme_fall = pme_q & ~pme_status_i;

  // power-up domain: wake status and PME edge tracker
  always_ff @(posedge clk) begin
    if (por_i) begin
      pme_q      <= 1'b0;
      evt_o.wake <= 1'b0;
    end else begin
      pme_q <= pme_status_i;
      if (wake_evt_i)
        evt_o.wake <= 1'b1;
      else if (pme_fall || clr_wake_i)
        evt_o.wake <= 1'b0;
    end
  end

  // hardware/software domain: interrupt status
  always_ff @(posedge clk) begin
    if (por_i || rst_i)
      evt_o.irq <= 1'b0;
    else if (irq_pend_i)
      evt_o.irq <= 1'b1;
    else if (clr_irq_i)
      evt_o.irq <= 1'b0;
  end

endmodule

// File: rtl/fev_mask_bits.sv
module fev_mask_bits
  import fev_pkg::*;
(
  input  logic  clk,
  input  logic  por_i,
  input  logic  rst_i,
  input  logic  wr_mask_i,
  input  logic  wake_en_d,
  input  logic  wake_en_we,
  input  logic  summ_en_d,
  input  logic  summ_en_we,
  input  logic  irq_en_d,
  input  logic  irq_en_we,
  output mask_t mask_o
);

  always_ff @(posedge clk) begin
    if (por_i) begin
      mask_o.wake_en <= 1'b0;
      mask_o.summ_en <= 1'b0;
    end else if (wr_mask_i) begin
      if (wake_en_we) mask_o.wake_en <= wake_en_d;
      if (summ_en_we) mask_o.summ_en <= summ_en_d;
    end
  end

  always_ff @(posedge clk) begin
    if (por_i || rst_i)
      mask_o.irq_en <= 1'b0;
    else if (wr_mask_i && irq_en_we)
      mask_o.irq_en <= irq_en_d;
  end

endmodule

// File: rtl/fn_event_regs.sv
module fn_event_regs
  import fev_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] BASE_OFF = 8'h80
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic                rst_i,
  input  logic                mem_space_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] be_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                ready_o,
  input  logic                wake_evt_i,
  input  logic                irq_pend_i,
  input  logic                pme_status_i,
  input  logic                pme_enable_i,
  output logic                status_change_o,
  output logic                irq_o
);

  localparam int BE_W      = DATA_W / 8;
  localparam int WAKE_LANE = WAKE_BIT / 8;
  localparam int SUMM_LANE = SUMM_BIT / 8;
  localparam int IRQ_LANE  = IRQ_BIT / 8;

  sel_e  sel;
  logic  acc;
  logic  wr_evt;
  logic  wr_mask;
  evt_t  evt_q;
  mask_t mask_q;
  logic [DATA_W-1:0] rd_word;
  logic  unused_inputs;

  assign unused_inputs = &{1'b0, wdata_i, be_i};

  fev_decode #(
    .ADDR_W  (ADDR_W),
    .BASE_OFF(BASE_OFF)
  ) u_dec (
    .mem_space_i(mem_space_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .sel_o      (sel),
    .acc_o      (acc),
    .wr_evt_o   (wr_evt),
    .wr_mask_o  (wr_mask)
  );

  fev_event_bits u_evt (
    .clk         (clk),
    .por_i       (por_i),
    .rst_i       (rst_i),
    .wake_evt_i  (wake_evt_i),
    .irq_pend_i  (irq_pend_i),
    .pme_status_i(pme_status_i),
    .clr_wake_i  (wr_evt & be_i[WAKE_LANE] & wdata_i[WAKE_BIT]),
    .clr_irq_i   (wr_evt & be_i[IRQ_LANE] & wdata_i[IRQ_BIT]),
    .evt_o       (evt_q)
  );

  fev_mask_bits u_mask (
    .clk       (clk),
    .por_i     (por_i),
    .rst_i     (rst_i),
    .wr_mask_i (wr_mask),
    .wake_en_d (wdata_i[WAKE_BIT]),
    .wake_en_we(be_i[WAKE_LANE]),
    .summ_en_d (wdata_i[SUMM_BIT]),
    .summ_en_we(be_i[SUMM_LANE]),
    .irq_en_d  (wdata_i[IRQ_BIT]),
    .irq_en_we (be_i[IRQ_LANE]),
    .mask_o    (mask_q)
  );

  // read mux; reserved bits stay 0
  always_comb begin
    rd_word = '0;
    unique case (sel)
      SEL_EVT: begin
        rd_word[WAKE_BIT] = evt_q.wake;
        rd_word[IRQ_BIT]  = evt_q.irq;
      end
      SEL_MASK: begin
        rd_word[WAKE_BIT] = mask_q.wake_en;
        rd_word[SUMM_BIT] = mask_q.summ_en;
        rd_word[IRQ_BIT]  = mask_q.irq_en;
      end
      SEL_PRES: begin
        rd_word[WAKE_BIT] = wake_evt_i;
        rd_word[IRQ_BIT]  = irq_pend_i;
      end
      default: rd_word = '0;
    endcase
  end

  // registered bus response
  always_ff @(posedge clk) begin
    if (por_i) begin
      ready_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= acc;
      rdata_o <= (acc && rd_i) ? rd_word : '0;
    end
  end

  // registered event outputs
  always_ff @(posedge clk) begin
    if (por_i)
      status_change_o <= 1'b0;
    else
      status_change_o <= evt_q.wake & mask_q.wake_en & mask_q.summ_en & pme_enable_i;
  end

  always_ff @(posedge clk) begin
    if (por_i || rst_i)
      irq_o <= 1'b0;
    else
      irq_o <= evt_q.irq & mask_q.irq_en;
  end

  initial begin
    if (DATA_W < 16 || DATA_W % 8 != 0) $error("DATA_W must be a multiple of 8, at least 16");
    if (BE_W < 2) $error("need at least two byte lanes");
  end

endmodule

// File: rtl/fev_chk.sv
module fev_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] BASE_OFF = 8'h80
) (
  input logic              clk,
  input logic              por_i,
  input logic              rst_i,
  input logic              mem_space_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wake_evt_i,
  input logic              pme_enable_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ready_o,
  input logic              status_change_o,
  input logic              irq_o,
  input logic              evt_wake
);

  logic mapped;
  assign mapped = (addr_i == BASE_OFF) || (addr_i == ADDR_W'(BASE_OFF + 4)) ||
                  (addr_i == ADDR_W'(BASE_OFF + 8));

  AST_READY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (por_i)
    (mem_space_i && (rd_i || wr_i)) |=> ready_o);  // R11

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (por_i)
    (!rd_i && !wr_i) |=> (!ready_o && rdata_o == '0));  // R11

  AST_IO_SPACE_IGNORED: assert property (@(posedge clk) disable iff (por_i)
    (!mem_space_i && (rd_i || wr_i)) |=> (!ready_o && rdata_o == '0));  // R2

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (por_i)
    (mem_space_i && rd_i && !mapped) |=> (rdata_o == '0));  // R1

  AST_NO_WAKE_WITHOUT_PME: assert property (@(posedge clk) disable iff (por_i)
    !pme_enable_i |=> !status_change_o);  // R7

  AST_IRQ_LOW_AFTER_RST: assert property (@(posedge clk) disable iff (por_i)
    rst_i |=> !irq_o);  // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (por_i)
    wake_evt_i |=> evt_wake);  // R9

endmodule

bind fn_event_regs fev_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .BASE_OFF(BASE_OFF)
) u_fev_chk (
  .clk            (clk),
  .por_i          (por_i),
  .rst_i          (rst_i),
  .mem_space_i    (mem_space_i),
  .rd_i           (rd_i),
  .wr_i           (wr_i),
  .addr_i         (addr_i),
  .wake_evt_i     (wake_evt_i),
  .pme_enable_i   (pme_enable_i),
  .rdata_o        (rdata_o),
  .ready_o        (ready_o),
  .status_change_o(status_change_o),
  .irq_o          (irq_o),
  .evt_wake       (evt_q.wake)
);

// File: tb/fn_event_regs_test.sv
module fn_event_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          por_i = 1'b1, rst_i = 1'b0;
  logic          mem_space_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [3:0]    be_i = '0;
  logic [DW-1:0] rdata_o;
  logic          ready_o;
  logic          wake_evt_i = 1'b0, irq_pend_i = 1'b0;
  logic          pme_status_i = 1'b0, pme_enable_i = 1'b0;
  logic          status_change_o, irq_o;

  int total = 0;
  int bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  fn_event_regs uut (
    .clk(clk), .por_i(por_i), .rst_i(rst_i), .mem_space_i(mem_space_i),
    .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i), .be_i(be_i),
    .rdata_o(rdata_o), .ready_o(ready_o), .wake_evt_i(wake_evt_i),
    .irq_pend_i(irq_pend_i), .pme_status_i(pme_status_i),
    .pme_enable_i(pme_enable_i), .status_change_o(status_change_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit m_wake, m_irq, m_wen, m_sen, m_ien, m_pme;
  bit m_stc, m_irqo, m_ready;
  int unsigned m_rdata;

  always @(posedge clk) begin
    int unsigned word;
    bit acc, wev, wmk;
    if (por_i) begin
      {m_wake, m_irq, m_wen, m_sen, m_ien, m_pme, m_stc, m_irqo, m_ready} = '0;
      m_rdata = 0;
    end else begin
      acc = mem_space_i && (rd_i || wr_i);
      wev = wr_i && mem_space_i && addr_i == 8'h80;
      wmk = wr_i && mem_space_i && addr_i == 8'h84;
      word = 0;
      if (mem_space_i) begin
        if (addr_i == 8'h80) word = (m_wake ? 32'h10 : 0) | (m_irq ? 32'h8000 : 0);
        if (addr_i == 8'h84) word = (m_wen ? 32'h10 : 0) | (m_sen ? 32'h4000 : 0) | (m_ien ? 32'h8000 : 0);
        if (addr_i == 8'h88) word = (wake_evt_i ? 32'h10 : 0) | (irq_pend_i ? 32'h8000 : 0);
      end
      m_ready = acc;
      m_rdata = (acc && rd_i) ? word : 0;
      m_stc   = m_wake && m_wen && m_sen && pme_enable_i;
      m_irqo  = !rst_i && m_irq && m_ien;
      if (wake_evt_i) m_wake = 1;
      else if ((m_pme && !pme_status_i) || (wev && be_i[0] && wdata_i[4])) m_wake = 0;
      m_pme = pme_status_i;
      if (rst_i) m_irq = 0;
      else if (irq_pend_i) m_irq = 1;
      else if (wev && be_i[1] && wdata_i[15]) m_irq = 0;
      if (wmk && be_i[0]) m_wen = wdata_i[4];
      if (wmk && be_i[1]) m_sen = wdata_i[14];
      if (rst_i) m_ien = 0;
      else if (wmk && be_i[1]) m_ien = wdata_i[15];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R11 rdata model", rdata_o, m_rdata);
      check("R11 ready model", {31'b0, ready_o}, {31'b0, m_ready});
      check("R7 status_change model", {31'b0, status_change_o}, {31'b0, m_stc});
      check("R8 irq model", {31'b0, irq_o}, {31'b0, m_irqo});
    end
  end

  // tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be,
                    input logic mem = 1'b1);
    wr_i = 1; addr_i = a; wdata_i = d; be_i = be; mem_space_i = mem;
    @(negedge clk);
    wr_i = 0; mem_space_i = 0; wdata_i = 0; be_i = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag,
                        input logic mem = 1'b1);
    rd_i = 1; addr_i = a; mem_space_i = mem;
    @(negedge clk);
    check(tag, rdata_o, exp);
    check({tag, " ready"}, {31'b0, ready_o}, {31'b0, mem});
    rd_i = 0; mem_space_i = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_i = 0;
    @(negedge clk);
    cmp_en = 1;
    // reset state
    rd_chk(8'h80, 32'h0, "R3 event after por");
    rd_chk(8'h84, 32'h0, "R6 mask after por");
    check("R7 no status change after por", {31'b0, status_change_o}, 32'h0);
    // mask write and reserved bits
    wr(8'h84, 32'h0000_C010, 4'hF);
    rd_chk(8'h84, 32'h0000_C010, "R6 mask readback");
    wr(8'h84, 32'hFFFF_FFFF, 4'hF);
    rd_chk(8'h84, 32'h0000_C010, "R11 reserved mask bits");
    // wake and PME gating
    pulse(wake_evt_i);
    rd_chk(8'h80, 32'h10, "R3 wake set");
    check("R7 gated by pme enable", {31'b0, status_change_o}, 32'h0);
    pme_enable_i = 1;
    @(negedge clk);
    check("R7 status change asserted", {31'b0, status_change_o}, 32'h1);
    // rst keeps wake domain
    pulse(rst_i);
    rd_chk(8'h80, 32'h10, "R3 wake survives rst");
    rd_chk(8'h84, 32'h0000_4010, "R6 irq enable cleared by rst");
    check("R7 still asserted after rst", {31'b0, status_change_o}, 32'h1);
    // write-1-clear on the wrong lane then the right lane
    wr(8'h80, 32'h10, 4'h2);
    rd_chk(8'h80, 32'h10, "R11 disabled lane ignored");
    wr(8'h80, 32'h10, 4'h1);
    rd_chk(8'h80, 32'h0, "R3 w1c wake");
    check("R7 deasserted after clear", {31'b0, status_change_o}, 32'h0);
    // PME status falling edge
    pulse(wake_evt_i);
    pme_status_i = 1;
    repeat (2) @(negedge clk);
    rd_chk(8'h80, 32'h10, "R4 level high keeps wake");
    pme_status_i = 0;
    @(negedge clk);
    rd_chk(8'h80, 32'h0, "R4 auto clear on fall");
    // interrupt path
    wr(8'h84, 32'h0000_C010, 4'hF);
    pulse(irq_pend_i);
    rd_chk(8'h80, 32'h8000, "R5 irq sticky");
    check("R8 irq asserted", {31'b0, irq_o}, 32'h1);
    pulse(rst_i);
    check("R8 irq low after rst", {31'b0, irq_o}, 32'h0);
    rd_chk(8'h80, 32'h0, "R5 irq cleared by rst");
    // set wins over clear
    wake_evt_i = 1;
    wr(8'h80, 32'h10, 4'hF);
    wake_evt_i = 0;
    rd_chk(8'h80, 32'h10, "R9 set beats clear");
    // present state
    irq_pend_i = 1;
    rd_chk(8'h88, 32'h8000, "R10 live levels");
    wr(8'h88, 32'hFFFF_FFFF, 4'hF);
    rd_chk(8'h84, 32'h0000_4010, "R10 write to present ignored");
    irq_pend_i = 0;
    rd_chk(8'h88, 32'h0, "R10 live level dropped");
    rd_chk(8'h80, 32'h8010, "R5 irq set while pending");
    // I/O space ignored
    wr(8'h84, 32'h0, 4'hF, 1'b0);
    check("R2 no ready on io write", {31'b0, ready_o}, 32'h0);
    rd_chk(8'h84, 32'h0000_4010, "R2 io write ignored");
    rd_chk(8'h84, 32'h0, "R2 io read returns 0", 1'b0);
    // unmapped addresses
    rd_chk(8'h8C, 32'h0, "R1 offset 0x8C reads 0");
    rd_chk(8'h40, 32'h0, "R1 unmapped reads 0");
    // power-up reset clears everything
    pulse(por_i);
    rd_chk(8'h84, 32'h0, "R6 por clears mask");
    rd_chk(8'h80, 32'h0, "R3 por clears wake");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule